// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a register file that presents a fixed 16-register logical view onto a larger physical array. Each logical register number is added to a window base to form the physical index. A call strobe slides the base forward by 12 entries, and a return strobe slides it back by 12. The caller's four highest registers, R12 to R15, are therefore the same storage as the callee's R0 to R3. Arguments are written there before a call and results are read back from there after the return, with no memory traffic.

There are two combinational read ports and one synchronous write port. A call that would carry the view past the end of the physical array is refused and raises the overflow flag in the same cycle. A return issued while the base is already at zero is refused and raises the underflow flag. Saving frames to memory and restoring them is left to surrounding logic, which watches these flags. Reset returns the base to zero and leaves the stored values as they were.

Top module: `regwin_file`

## Requirements
- R1: A synchronous reset (active-high `rst`) sets the window base to 0 and holds both flags low, so logical Rn reads physical entry n. Stored register values are not cleared by reset.
- R2: Each read port is combinational: the data output shows physical entry base + index in the same cycle the index is applied.
- R3: A write with `wr_en` high stores `wr_data` at physical entry base + `wr_idx` on the rising clock edge. The new value can be read from the next cycle on.
- R4: An accepted call (`call` high, `ret` low) adds 12 to the base at the clock edge. The values the caller held in R12, R13, R14 and R15 are read afterwards as R0, R1, R2 and R3.
- R5: An accepted return (`ret` high, `call` low, base nonzero) subtracts 12 from the base. Values the callee wrote to R0 to R3 are read by the caller as R12 to R15.
- R6: The callee's R4 to R15 map to storage disjoint from the caller's R0 to R11. The caller's R0 to R11 therefore hold their values across a call and return.
- R7: When base + 12 + 15 would exceed PHYS_REGS - 1 (with 64 entries, this happens at base 48), `call` raises `ovf` combinationally in that cycle. The base is not changed.
- R8: When the base is 0, `ret` raises `unf` combinationally in that cycle. The base is not changed.
- R9: A write issued in the same cycle as an accepted call uses the old base. For example, a write to R13 together with a call is read afterwards as R1.
- R10: When `call` and `ret` are both high, the base does not move and neither flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Logical register number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical register number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Write data |
| call | input | 1 | Slide the window forward by 12 |
| ret | input | 1 | Slide the window back by 12 |
| ovf | output | 1 | Call refused: no room above the current window |
| unf | output | 1 | Return refused: base already zero |

## Verification
The assertions assume that `call` and `ret` are never left unknown while reset is low. They also assume that the base only ever moves in steps of 12, so a return with a nonzero base always has a full step to go back. The stimulus drives every control input to a defined 0 or 1 from time zero and changes inputs only on falling clock edges. It writes every register before reading it, because reset leaves the array contents undefined. Calls and returns are issued only through strobes, so the base stays on the multiples of 12 that the assertions rely on.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W    = 16,
  parameter int PHYS_REGS = 64,
  parameter int VIEW_REGS = 16,
  parameter int SLIDE     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              call,
  input  logic              ret,
  output logic              ovf,
  output logic              unf
);
  localparam int PA_W     = $clog2(PHYS_REGS);
  localparam int MAX_BASE = PHYS_REGS - VIEW_REGS;

  logic [PA_W-1:0]   base_q;
  logic [DATA_W-1:0] regs_q [PHYS_REGS];
  logic [PA_W:0]     base_up;
  logic [PA_W-1:0]   pa_a, pa_b, pa_w;
  logic              call_only, ret_only, do_call, do_ret;

  assign base_up   = {1'b0, base_q} + (PA_W+1)'(SLIDE);
  assign call_only = call & ~ret;
  assign ret_only  = ret & ~call;
  assign do_call   = call_only & (base_up <= (PA_W+1)'(MAX_BASE));
  assign do_ret    = ret_only & (base_q != '0);
  assign ovf       = call_only & ~do_call;
  assign unf       = ret_only & (base_q == '0);

  assign pa_a = base_q + PA_W'(rd_a_idx);
  assign pa_b = base_q + PA_W'(rd_b_idx);
  assign pa_w = base_q + PA_W'(wr_idx);

  assign rd_a_data = regs_q[pa_a];
  assign rd_b_data = regs_q[pa_b];

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (do_call) base_q <= base_up[PA_W-1:0];
    else if (do_ret)  base_q <= base_q - PA_W'(SLIDE);
  end

  always_ff @(posedge clk) begin
    if (wr_en) regs_q[pa_w] <= wr_data;
  end

  a_r1_reset_base: assert property (@(posedge clk) rst |=> base_q == '0);

  a_r1_bound: assert property (@(posedge clk) disable iff (rst)
    base_q <= PA_W'(MAX_BASE));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs_q[$past(pa_w)] == $past(wr_data));

  a_r4_call_slide: assert property (@(posedge clk) disable iff (rst)
    (call && !ret && !ovf) |=> base_q == $past(base_q) + PA_W'(SLIDE));

  a_r5_ret_slide: assert property (@(posedge clk) disable iff (rst)
    (ret && !call && !unf) |=> base_q == $past(base_q) - PA_W'(SLIDE));

  a_r7_no_overflow_move: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(base_q));

  a_r8_no_underflow_move: assert property (@(posedge clk) disable iff (rst)
    unf |=> $stable(base_q));

  a_r10_both_strobes: assert property (@(posedge clk) disable iff (rst)
    (call && ret) |=> $stable(base_q));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));
endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, call = 1'b0, ret = 1'b0;
  logic        ovf, unf;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  regwin_file u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .call(call), .ret(ret), .ovf(ovf), .unf(unf)
  );

  // op: 0 write, 1 read A, 2 read B, 3 call, 4 return
  localparam int NV = 22;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 4'd12, 16'hA001}, {3'd0, 4'd13, 16'hA002},
    {3'd0, 4'd14, 16'hA003}, {3'd0, 4'd15, 16'hA004},
    {3'd0, 4'd0,  16'hC000}, {3'd0, 4'd11, 16'hC00B},
    {3'd1, 4'd12, 16'hA001}, {3'd2, 4'd0,  16'hC000},
    {3'd3, 4'd0,  16'h0000},
    {3'd1, 4'd0,  16'hA001}, {3'd2, 4'd3,  16'hA004},
    {3'd0, 4'd4,  16'hD004}, {3'd0, 4'd0,  16'hE000},
    {3'd3, 4'd0,  16'h0000}, {3'd0, 4'd15, 16'hF00F},
    {3'd4, 4'd0,  16'h0000},
    {3'd1, 4'd4,  16'hD004}, {3'd2, 4'd0,  16'hE000},
    {3'd4, 4'd0,  16'h0000},
    {3'd1, 4'd12, 16'hE000}, {3'd2, 4'd11, 16'hC00B},
    {3'd1, 4'd13, 16'hA002}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; call = 1'b0; ret = 1'b0;
  endtask

  task automatic put(input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk); idle(); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic strobe(input logic c, input logic r);
    @(negedge clk); idle(); call = c; ret = r;
    @(negedge clk); idle();
  endtask

  task automatic peek(input string req, input logic [3:0] idx, input logic [15:0] exp);
    @(negedge clk); idle(); rd_a_idx = idx; #5;
    chk(req, rd_a_data, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    chk("R1 ovf after reset", {15'd0, ovf}, 16'd0);
    chk("R1 unf after reset", {15'd0, unf}, 16'd0);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VEC[i][22:20])
        3'd0: begin wr_en = 1'b1; wr_idx = VEC[i][19:16]; wr_data = VEC[i][15:0]; end
        3'd1: begin rd_a_idx = VEC[i][19:16]; #5; chk("R2/R4/R5/R6 port A", rd_a_data, VEC[i][15:0]); end
        3'd2: begin rd_b_idx = VEC[i][19:16]; #5; chk("R2/R4/R5/R6 port B", rd_b_data, VEC[i][15:0]); end
        3'd3: begin call = 1'b1; #5; chk("R4 no ovf", {15'd0, ovf}, 16'd0); end
        default: begin ret = 1'b1; #5; chk("R5 no unf", {15'd0, unf}, 16'd0); end
      endcase
    end
    @(negedge clk); idle();

    // R8: return at base 0
    @(negedge clk); ret = 1'b1; #5;
    chk("R8 unf raised", {15'd0, unf}, 16'd1);
    @(negedge clk); idle();
    peek("R8 base held", 4'd12, 16'hE000);

    // R10: call and return together
    @(negedge clk); call = 1'b1; ret = 1'b1; #5;
    chk("R10 no ovf", {15'd0, ovf}, 16'd0);
    chk("R10 no unf", {15'd0, unf}, 16'd0);
    @(negedge clk); idle();
    peek("R10 base held", 4'd0, 16'hC000);

    // R9: write with call uses old base
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd13; wr_data = 16'h9999; call = 1'b1;
    @(negedge clk); idle();
    peek("R9 write at old base", 4'd1, 16'h9999);

    // R7: climb to base 48 then refused call
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    put(4'd0, 16'h4848);
    put(4'd15, 16'h4F4F);
    @(negedge clk); call = 1'b1; #5;
    chk("R7 ovf raised", {15'd0, ovf}, 16'd1);
    @(negedge clk); idle();
    peek("R7 base held R0", 4'd0, 16'h4848);
    peek("R7 base held R15", 4'd15, 16'h4F4F);

    // R1: reset returns base to 0 and keeps contents
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    peek("R1 contents kept R12", 4'd12, 16'hE000);
    peek("R1 contents kept R0", 4'd0, 16'hC000);

    finish_run();
  end
endmodule